// File: doc/BRIEF.md
# Home Directory Controller with Migratory Sharing Detection

This block is the home-side coherence directory for a set of memory blocks shared by a fixed number of caching nodes. It receives three kinds of requests from nodes (read, ordinary write carrying data, and a write flagged as possibly migratory). It sends coherence messages as one multicast message per cycle, whose destination is a node mask. It collects the replies that caches return. For every block it keeps a sharer mask, a stable or waiting state, a migratory flag, and two writer pointers that hold the most recent writer and the writer before it.

Ordinary blocks follow a competitive-update policy. A write pushes the new word to every other sharer. Each sharer either keeps its copy or drops it, and the writer is granted sole ownership when nobody else is left. A block whose write pattern hands it from one node to the next is classified as migratory. That happens only when the writer is neither of the two most recent writers and every sharer agrees to give up its copy. Reads to a migratory block move the only copy from the current owner to the reader. The block returns to ordinary handling once an owner reports that it never modified its copy.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is clean (memory holds the data), ordinary, with no sharers and both writer pointers at node 0. `msg_valid` is low and `req_ready` is high.
- R2: A read (`req_kind` 0) to a clean block produces, one cycle after acceptance, DATA (`msg_kind` 4) addressed to the requester only, and adds the requester to the sharers.
- R3: A read to an owned ordinary block sends FETCH (2) to the owner. After the owner's write-back reply (`rsp_kind` 4), DATA goes to the requester, the block becomes clean, and both nodes are sharers.
- R4: A write (`req_kind` 1 or 3) moves the last-writer pointer into the last-last-writer pointer and records the requester. It sends UPDATE (0) to every sharer except the requester, and clears the migratory flag.
- R5: During a write, a keep reply (0) leaves the replying node a sharer and a drop reply (1) removes it. When the replies complete, WRITE-ACK-EXCLUSIVE (7) goes to the writer and the block becomes owned if no other sharer remains. Otherwise WRITE-ACK (6) is sent and the block becomes clean. A write with no other sharers is granted exclusively at once.
- R6: The number of replies awaited equals the number of nodes addressed. No reply to the requester leaves before the last of them arrives.
- R7: A migratory write (`req_kind` 2) from a node equal to either writer pointer is handled exactly like an ordinary write.
- R8: Any other migratory write sends QUERY (1) to the other sharers. If all of them answer agree (2, which also drops the copy), the writer gets MIGRATORY-ACK (8), becomes sole owner, and the block is marked migratory. If any answers refuse (3), the writer gets WRITE-ACK (6) and the block stays ordinary and clean. With no other sharer the migratory grant is immediate.
- R9: A read to a migratory block sends READ-INVALIDATE (3) to the owner. A still-migratory reply (5) makes the requester sole owner through EXCLUSIVE-DATA (5), and the block stays migratory.
- R10: A not-modified reply (6) to a read-invalidate makes the block ordinary and clean. The requester gets DATA (4), and owner and requester are both sharers.
- R11: `req_ready` is low while the addressed block awaits replies or while a reply is being presented. Requests to other blocks are accepted while one block waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_kind | input | 2 | 0 read, 1 or 3 write, 2 migratory write |
| req_node | input | NID_W (4) | Requesting node id |
| req_blk | input | BLK_W (3) | Block index |
| rsp_valid | input | 1 | Cache reply present |
| rsp_kind | input | 3 | 0 keep, 1 drop, 2 agree, 3 refuse, 4 write-back, 5 still migratory, 6 not modified |
| rsp_node | input | NID_W (4) | Replying node id |
| rsp_blk | input | BLK_W (3) | Block the reply refers to |
| msg_valid | output | 1 | Outgoing message present |
| msg_kind | output | 4 | 0 update, 1 query, 2 fetch, 3 read-invalidate, 4 data, 5 exclusive data, 6 write-ack, 7 write-ack exclusive, 8 migratory-ack |
| msg_dest | output | NODES (16) | Destination node mask |
| msg_blk | output | BLK_W (3) | Block the message refers to |

## Verification
A corrupted sharer mask shows up at the ports on the next request to that block, as a wrong destination mask on an update, query or fetch. A wrong writer pointer shows up on the next migratory write, which then picks query instead of update or the reverse. A miscounted reply counter makes the write acknowledgment leave one reply early or never, so that fault is visible within the transaction itself. A stuck migratory flag turns the next read's fetch into a read-invalidate, which is visible one cycle after that read is accepted.

// File: rtl/dir_home_pkg.sv
package dir_home_pkg;

   typedef enum logic [1:0] {
      RQ_READ   = 2'd0,
      RQ_WRITE  = 2'd1,
      RQ_MWRITE = 2'd2,
      RQ_WRITE2 = 2'd3
   } req_kind_e;

   typedef enum logic [2:0] {
      RS_KEEP   = 3'd0,
      RS_DROP   = 3'd1,
      RS_AGREE  = 3'd2,
      RS_REFUSE = 3'd3,
      RS_WBACK  = 3'd4,
      RS_STILL  = 3'd5,
      RS_LEFT   = 3'd6
   } rsp_kind_e;

   typedef enum logic [3:0] {
      MS_UPDATE  = 4'd0,
      MS_QUERY   = 4'd1,
      MS_FETCH   = 4'd2,
      MS_RDINV   = 4'd3,
      MS_DATA    = 4'd4,
      MS_XDATA   = 4'd5,
      MS_WACK    = 4'd6,
      MS_WACK_EX = 4'd7,
      MS_MWACK   = 4'd8
   } msg_kind_e;

   typedef enum logic [2:0] {
      BS_CLEAN    = 3'd0,
      BS_OWNED    = 3'd1,
      BS_RD_WAIT  = 3'd2,
      BS_WR_WAIT  = 3'd3,
      BS_QRY_WAIT = 3'd4,
      BS_MRD_WAIT = 3'd5
   } blk_state_e;

endpackage

// File: rtl/dir_target_calc.sv
module dir_target_calc #(
   parameter int NODES = 16,
   localparam int NID_W = $clog2(NODES),
   localparam int CNT_W = $clog2(NODES + 1)
) (
   input  logic [NODES-1:0] sharers,
   input  logic [NID_W-1:0] src,
   output logic [NODES-1:0] self_mask,
   output logic [NODES-1:0] targets,
   output logic [CNT_W-1:0] tcount
);
   for (genvar i = 0; i < NODES; i++) begin : g_self
      assign self_mask[i] = (src == NID_W'(i));
   end

   assign targets = sharers & ~self_mask;

   always_comb begin
      tcount = '0;
      for (int i = 0; i < NODES; i++) begin
         tcount = tcount + CNT_W'(targets[i]);
      end
   end

   always_comb begin
      assert_self_onehot_R4: assert ($onehot(self_mask));
   end
endmodule

// File: rtl/dir_writer_match.sv
module dir_writer_match #(
   parameter int NID_W        = 4,
   parameter bit USE_TWO_PTRS = 1'b1
) (
   input  logic [NID_W-1:0] src,
   input  logic [NID_W-1:0] last_w,
   input  logic [NID_W-1:0] prev_w,
   output logic             is_prior
);
   if (USE_TWO_PTRS) begin : g_two
      assign is_prior = (src == last_w) || (src == prev_w);
   end else begin : g_one
      logic unused_prev;
      assign unused_prev = ^prev_w;
      assign is_prior = (src == last_w);
   end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
   import dir_home_pkg::*;
#(
   parameter int NODES        = 16,
   parameter int NBLK         = 8,
   parameter bit USE_TWO_PTRS = 1'b1,
   localparam int NID_W = $clog2(NODES),
   localparam int BLK_W = $clog2(NBLK),
   localparam int CNT_W = $clog2(NODES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [1:0]       req_kind,
   input  logic [NID_W-1:0] req_node,
   input  logic [BLK_W-1:0] req_blk,
   input  logic             rsp_valid,
   input  logic [2:0]       rsp_kind,
   input  logic [NID_W-1:0] rsp_node,
   input  logic [BLK_W-1:0] rsp_blk,
   output logic             msg_valid,
   output logic [3:0]       msg_kind,
   output logic [NODES-1:0] msg_dest,
   output logic [BLK_W-1:0] msg_blk
);
   if (NODES < 2 || NBLK < 2) begin : g_bad_params
      initial $fatal(1, "dir_home_ctrl: NODES and NBLK must both be at least 2");
   end

   localparam logic [NODES-1:0] ONE_N = NODES'(1);

   // per-block directory entry
   blk_state_e       st_q     [NBLK];
   logic [NODES-1:0] pres_q   [NBLK];
   logic             mig_q    [NBLK];
   logic [NID_W-1:0] lw_q     [NBLK];
   logic [NID_W-1:0] llw_q    [NBLK];
   logic [NID_W-1:0] rq_q     [NBLK];
   logic [CNT_W-1:0] cnt_q    [NBLK];
   logic             refuse_q [NBLK];

   logic             msg_valid_q;
   msg_kind_e        msg_kind_q;
   logic [NODES-1:0] msg_dest_q;
   logic [BLK_W-1:0] msg_blk_q;

   // request side decode
   logic [NODES-1:0] q_reqbit, q_targets;
   logic [CNT_W-1:0] q_tcount;
   logic             q_prior, q_mig_try, q_stable;

   dir_target_calc #(.NODES(NODES)) u_targets (
      .sharers   (pres_q[req_blk]),
      .src       (req_node),
      .self_mask (q_reqbit),
      .targets   (q_targets),
      .tcount    (q_tcount)
   );

   dir_writer_match #(.NID_W(NID_W), .USE_TWO_PTRS(USE_TWO_PTRS)) u_match (
      .src      (req_node),
      .last_w   (lw_q[req_blk]),
      .prev_w   (llw_q[req_blk]),
      .is_prior (q_prior)
   );

   assign q_mig_try = (req_kind == RQ_MWRITE) && !q_prior;
   assign q_stable  = (st_q[req_blk] == BS_CLEAN) || (st_q[req_blk] == BS_OWNED);
   assign req_ready = !rsp_valid && q_stable;

   // reply side decode
   logic [NODES-1:0] r_nodebit, r_reqbit, r_pres;
   logic             r_clear, r_last, r_others, r_refuse, r_ack_kind, r_qry_kind;

   always_comb begin
      r_nodebit  = ONE_N << rsp_node;
      r_reqbit   = ONE_N << rq_q[rsp_blk];
      r_clear    = (rsp_kind == RS_DROP) || (rsp_kind == RS_AGREE);
      r_pres     = r_clear ? (pres_q[rsp_blk] & ~r_nodebit) : pres_q[rsp_blk];
      r_last     = (cnt_q[rsp_blk] == CNT_W'(1));
      r_others   = |(r_pres & ~r_reqbit);
      r_refuse   = refuse_q[rsp_blk] || (rsp_kind == RS_REFUSE);
      r_ack_kind = (rsp_kind == RS_KEEP) || (rsp_kind == RS_DROP);
      r_qry_kind = (rsp_kind == RS_AGREE) || (rsp_kind == RS_REFUSE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NBLK; i++) begin
            st_q[i]     <= BS_CLEAN;
            pres_q[i]   <= '0;
            mig_q[i]    <= 1'b0;
            lw_q[i]     <= '0;
            llw_q[i]    <= '0;
            rq_q[i]     <= '0;
            cnt_q[i]    <= '0;
            refuse_q[i] <= 1'b0;
         end
         msg_valid_q <= 1'b0;
         msg_kind_q  <= MS_DATA;
         msg_dest_q  <= '0;
         msg_blk_q   <= '0;
      end else begin
         msg_valid_q <= 1'b0;
         if (rsp_valid) begin
            msg_blk_q <= rsp_blk;
            msg_dest_q <= r_reqbit;
            unique case (st_q[rsp_blk])
               BS_RD_WAIT: if (rsp_kind == RS_WBACK) begin
                  msg_valid_q     <= 1'b1;
                  msg_kind_q      <= MS_DATA;
                  pres_q[rsp_blk] <= pres_q[rsp_blk] | r_reqbit;
                  st_q[rsp_blk]   <= BS_CLEAN;
               end
               BS_MRD_WAIT: if (rsp_kind == RS_STILL) begin
                  msg_valid_q     <= 1'b1;
                  msg_kind_q      <= MS_XDATA;
                  pres_q[rsp_blk] <= r_reqbit;
                  st_q[rsp_blk]   <= BS_OWNED;
               end else if (rsp_kind == RS_LEFT) begin
                  msg_valid_q     <= 1'b1;
                  msg_kind_q      <= MS_DATA;
                  mig_q[rsp_blk]  <= 1'b0;
                  pres_q[rsp_blk] <= pres_q[rsp_blk] | r_reqbit;
                  st_q[rsp_blk]   <= BS_CLEAN;
               end
               BS_WR_WAIT: if (r_ack_kind) begin
                  cnt_q[rsp_blk] <= cnt_q[rsp_blk] - CNT_W'(1);
                  if (!r_last) begin
                     pres_q[rsp_blk] <= r_pres;
                  end else if (r_others) begin
                     msg_valid_q     <= 1'b1;
                     msg_kind_q      <= MS_WACK;
                     pres_q[rsp_blk] <= r_pres;
                     st_q[rsp_blk]   <= BS_CLEAN;
                  end else begin
                     msg_valid_q     <= 1'b1;
                     msg_kind_q      <= MS_WACK_EX;
                     pres_q[rsp_blk] <= r_reqbit;
                     st_q[rsp_blk]   <= BS_OWNED;
                  end
               end
               BS_QRY_WAIT: if (r_qry_kind) begin
                  cnt_q[rsp_blk]    <= cnt_q[rsp_blk] - CNT_W'(1);
                  refuse_q[rsp_blk] <= r_refuse;
                  if (!r_last) begin
                     pres_q[rsp_blk] <= r_pres;
                  end else if (r_refuse) begin
                     msg_valid_q     <= 1'b1;
                     msg_kind_q      <= MS_WACK;
                     pres_q[rsp_blk] <= r_pres;
                     st_q[rsp_blk]   <= BS_CLEAN;
                  end else begin
                     msg_valid_q     <= 1'b1;
                     msg_kind_q      <= MS_MWACK;
                     mig_q[rsp_blk]  <= 1'b1;
                     pres_q[rsp_blk] <= r_reqbit;
                     st_q[rsp_blk]   <= BS_OWNED;
                  end
               end
               default: ;
            endcase
         end else if (req_valid && req_ready) begin
            msg_valid_q <= 1'b1;
            msg_blk_q   <= req_blk;
            if (req_kind == RQ_READ) begin
               if (st_q[req_blk] == BS_OWNED) begin
                  msg_kind_q     <= mig_q[req_blk] ? MS_RDINV : MS_FETCH;
                  msg_dest_q     <= pres_q[req_blk];
                  st_q[req_blk]  <= mig_q[req_blk] ? BS_MRD_WAIT : BS_RD_WAIT;
                  rq_q[req_blk]  <= req_node;
                  cnt_q[req_blk] <= CNT_W'(1);
               end else begin
                  msg_kind_q      <= MS_DATA;
                  msg_dest_q      <= q_reqbit;
                  pres_q[req_blk] <= pres_q[req_blk] | q_reqbit;
               end
            end else begin
               lw_q[req_blk]  <= req_node;
               llw_q[req_blk] <= lw_q[req_blk];
               rq_q[req_blk]  <= req_node;
               cnt_q[req_blk] <= q_tcount;
               if (q_tcount == '0) begin
                  msg_kind_q      <= q_mig_try ? MS_MWACK : MS_WACK_EX;
                  msg_dest_q      <= q_reqbit;
                  mig_q[req_blk]  <= q_mig_try;
                  pres_q[req_blk] <= q_reqbit;
                  st_q[req_blk]   <= BS_OWNED;
               end else begin
                  msg_kind_q        <= q_mig_try ? MS_QUERY : MS_UPDATE;
                  msg_dest_q        <= q_targets;
                  mig_q[req_blk]    <= 1'b0;
                  refuse_q[req_blk] <= 1'b0;
                  pres_q[req_blk]   <= pres_q[req_blk] | q_reqbit;
                  st_q[req_blk]     <= q_mig_try ? BS_QRY_WAIT : BS_WR_WAIT;
               end
            end
         end
      end
   end

   assign msg_valid = msg_valid_q;
   assign msg_kind  = msg_kind_q;
   assign msg_dest  = msg_dest_q;
   assign msg_blk   = msg_blk_q;

   // every accepted request answers or forwards in the following cycle
   assert_accept_replies_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> msg_valid);

   // a reply counted against a waiting write never finds the counter empty
   assert_no_ack_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (st_q[rsp_blk] == BS_WR_WAIT || st_q[rsp_blk] == BS_QRY_WAIT))
      |-> (cnt_q[rsp_blk] != '0));

   // fan-out messages always address at least one node
   assert_fanout_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && (msg_kind == MS_UPDATE || msg_kind == MS_QUERY)) |-> (msg_dest != '0));

   for (genvar b = 0; b < NBLK; b++) begin : g_blk_chk
      assert_owned_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (st_q[b] == BS_OWNED) |-> $onehot(pres_q[b]));
      assert_mig_never_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
         mig_q[b] |-> (st_q[b] != BS_CLEAN));
   end
endmodule

// File: tb/tb_dir_home_ctrl.sv
`timescale 1ns/1ps
module tb_dir_home_ctrl;
   localparam int K_RD = 0, K_WR = 1, K_MW = 2;
   localparam int P_KEEP = 0, P_DROP = 1, P_AGREE = 2, P_REFUSE = 3, P_WBACK = 4,
                  P_STILL = 5, P_LEFT = 6;
   localparam int M_UPD = 0, M_QRY = 1, M_FETCH = 2, M_RDINV = 3, M_DATA = 4,
                  M_XDATA = 5, M_WACK = 6, M_WACKX = 7, M_MWACK = 8;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_ready;
   logic [1:0]  req_kind;
   logic [3:0]  req_node, rsp_node;
   logic [2:0]  req_blk, rsp_blk, msg_blk;
   logic        rsp_valid;
   logic [2:0]  rsp_kind;
   logic        msg_valid;
   logic [3:0]  msg_kind;
   logic [15:0] msg_dest;

   always #2 clk = ~clk;

   dir_home_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
      .req_node(req_node), .req_blk(req_blk),
      .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_node(rsp_node), .rsp_blk(rsp_blk),
      .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dest(msg_dest), .msg_blk(msg_blk)
   );

   int n_chk = 0, n_fail = 0;
   logic [15:0] m_pres [8];
   bit          m_mod  [8];
   bit          m_mig  [8];
   int          m_lw   [8];
   int          m_llw  [8];

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic check_msg(bit ev, int k, int d, int b, string tag);
      n_chk++;
      if (!ev) begin
         if (msg_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL %s unexpected message: actual kind %0d dest %0h, expected none",
                     tag, msg_kind, msg_dest);
         end
      end else if (msg_valid !== 1'b1 || msg_kind != 4'(k) || msg_dest != 16'(d) ||
                   msg_blk != 3'(b)) begin
         n_fail++;
         $display("FAIL %s message: actual v%0d kind %0d dest %0h blk %0d, expected kind %0d dest %0h blk %0d",
                  tag, msg_valid, msg_kind, msg_dest, msg_blk, k, d, b);
      end
   endtask

   task automatic issue_req(int k, int src, int blk);
      @(negedge clk);
      req_valid = 1'b1; req_kind = 2'(k); req_node = 4'(src); req_blk = 3'(blk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic issue_rsp(int k, int src, int blk);
      @(negedge clk);
      rsp_valid = 1'b1; rsp_kind = 3'(k); rsp_node = 4'(src); rsp_blk = 3'(blk);
      @(negedge clk);
      rsp_valid = 1'b0;
   endtask

   function automatic int first_one(logic [15:0] v);
      for (int i = 0; i < 16; i++) if (v[i]) return i;
      return 0;
   endfunction

   function automatic bit pick(int pol);
      if (pol == 0) return 1'b1;
      if (pol == 1) return 1'b0;
      return bit'($urandom % 2);
   endfunction

   // one complete transaction against the bench model; pol 0 = agree/drop/still,
   // 1 = refuse/keep/not-modified, 2 = random
   task automatic txn(int k, int src, int blk, int pol, string tag);
      logic [15:0] sb, tgt;
      bit rep, yes, refused;
      int left;
      sb = 16'(1) << src;
      issue_req(k, src, blk);
      if (k == K_RD) begin
         if (m_mod[blk] && m_mig[blk]) begin
            check_msg(1, M_RDINV, m_pres[blk], blk, tag);
            yes = pick(pol);
            issue_rsp(yes ? P_STILL : P_LEFT, first_one(m_pres[blk]), blk);
            if (yes) begin
               check_msg(1, M_XDATA, sb, blk, tag);
               m_pres[blk] = sb;
            end else begin
               check_msg(1, M_DATA, sb, blk, tag);
               m_pres[blk] |= sb; m_mod[blk] = 0; m_mig[blk] = 0;
            end
         end else if (m_mod[blk]) begin
            check_msg(1, M_FETCH, m_pres[blk], blk, tag);
            issue_rsp(P_WBACK, first_one(m_pres[blk]), blk);
            check_msg(1, M_DATA, sb, blk, tag);
            m_pres[blk] |= sb; m_mod[blk] = 0;
         end else begin
            check_msg(1, M_DATA, sb, blk, tag);
            m_pres[blk] |= sb;
         end
      end else begin
         rep = (src == m_lw[blk]) || (src == m_llw[blk]);
         m_llw[blk] = m_lw[blk]; m_lw[blk] = src;
         tgt = m_pres[blk] & ~sb;
         left = $countones(tgt);
         if (k == K_MW && !rep) begin
            if (tgt == 0) begin
               check_msg(1, M_MWACK, sb, blk, tag);
               m_pres[blk] = sb; m_mod[blk] = 1; m_mig[blk] = 1;
            end else begin
               check_msg(1, M_QRY, tgt, blk, tag);
               refused = 0;
               for (int i = 0; i < 16; i++) if (tgt[i]) begin
                  yes = pick(pol);
                  left--;
                  issue_rsp(yes ? P_AGREE : P_REFUSE, i, blk);
                  if (yes) m_pres[blk][i] = 1'b0; else refused = 1;
                  if (left > 0) check_msg(0, 0, 0, blk, tag);
               end
               if (!refused) begin
                  check_msg(1, M_MWACK, sb, blk, tag);
                  m_pres[blk] = sb; m_mod[blk] = 1; m_mig[blk] = 1;
               end else begin
                  check_msg(1, M_WACK, sb, blk, tag);
                  m_pres[blk] |= sb; m_mod[blk] = 0; m_mig[blk] = 0;
               end
            end
         end else begin
            m_mig[blk] = 0;
            if (tgt == 0) begin
               check_msg(1, M_WACKX, sb, blk, tag);
               m_pres[blk] = sb; m_mod[blk] = 1;
            end else begin
               check_msg(1, M_UPD, tgt, blk, tag);
               for (int i = 0; i < 16; i++) if (tgt[i]) begin
                  yes = pick(pol);
                  left--;
                  issue_rsp(yes ? P_DROP : P_KEEP, i, blk);
                  if (yes) m_pres[blk][i] = 1'b0;
                  if (left > 0) check_msg(0, 0, 0, blk, tag);
               end
               if ((m_pres[blk] & ~sb) == 0) begin
                  check_msg(1, M_WACKX, sb, blk, tag);
                  m_pres[blk] = sb; m_mod[blk] = 1;
               end else begin
                  check_msg(1, M_WACK, sb, blk, tag);
                  m_pres[blk] |= sb; m_mod[blk] = 0;
               end
            end
         end
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int seed_prime, k, s, b;
      seed_prime = $urandom(32'd20240611);
      for (int i = 0; i < 8; i++) begin
         m_pres[i] = '0; m_mod[i] = 0; m_mig[i] = 0; m_lw[i] = 0; m_llw[i] = 0;
      end
      rst_n = 1'b0; req_valid = 0; req_kind = 0; req_node = 0; req_blk = 0;
      rsp_valid = 0; rsp_kind = 0; rsp_node = 0; rsp_blk = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(msg_valid == 1'b0, "R1", "msg_valid after reset", msg_valid, 0);
      chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);

      // R2 reads to a clean block
      txn(K_RD, 1, 0, 2, "R2");
      txn(K_RD, 2, 0, 2, "R2");

      // R4 write fans out; R11 hold-back while block 0 waits
      issue_req(K_WR, 3, 0);
      check_msg(1, M_UPD, 16'h0006, 0, "R4");
      m_llw[0] = m_lw[0]; m_lw[0] = 3;
      @(negedge clk);
      req_valid = 1; req_kind = 2'(K_RD); req_node = 4'd5; req_blk = 3'd0;
      #1 chk(req_ready == 1'b0, "R11", "ready for waiting block", req_ready, 0);
      req_blk = 3'd1;
      #1 chk(req_ready == 1'b1, "R11", "ready for idle block", req_ready, 1);
      @(negedge clk);
      req_valid = 0;
      check_msg(1, M_DATA, 16'h0020, 1, "R11");
      m_pres[1] = 16'h0020;
      @(negedge clk);
      rsp_valid = 1; rsp_kind = 3'(P_KEEP); rsp_node = 4'd1; rsp_blk = 3'd0;
      req_valid = 1; req_kind = 2'(K_RD); req_node = 4'd6; req_blk = 3'd1;
      #1 chk(req_ready == 1'b0, "R11", "ready while reply present", req_ready, 0);
      @(negedge clk);
      rsp_valid = 0; req_valid = 0;
      check_msg(0, 0, 0, 0, "R6");
      issue_rsp(P_DROP, 2, 0);
      check_msg(1, M_WACK, 16'h0008, 0, "R5");
      m_pres[0] = 16'h000A; m_mod[0] = 0;

      txn(K_MW, 3, 0, 0, "R7");    // writer equals last writer: update path
      txn(K_RD, 7, 0, 2, "R3");    // owned ordinary block: fetch then data
      txn(K_MW, 7, 0, 0, "R8");    // all sharers agree: migratory
      txn(K_RD, 9, 0, 0, "R9");    // still migratory: exclusive copy moves
      txn(K_RD, 10, 0, 1, "R10");  // owner never wrote: back to ordinary
      txn(K_MW, 12, 0, 1, "R8");   // a sharer refuses: stays ordinary
      txn(K_MW, 7, 0, 2, "R7");    // writer equals last-last writer
      txn(K_WR, 4, 2, 2, "R5");    // no other sharer: immediate exclusive grant

      for (int n = 0; n < 500; n++) begin
         k = $urandom % 3; s = $urandom % 16; b = $urandom % 8;
         txn(k, s, b, 2, (k == K_RD) ? "R2" : ((k == K_WR) ? "R4" : "R8"));
      end

      summary();
      $finish;
   end
endmodule